// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Tail-Chaining

This block gathers 41 maskable interrupt request lines, each with its own enable bit and a 4-bit priority, and decides which one the processor core should take next. A lower numeric priority is more urgent. Among the pending, enabled lines it picks the most urgent one and hands its line number to the core as the vector identifier, so no software lookup is needed. A new request interrupts the running handler only if its priority is strictly more urgent than the most urgent handler currently active.

Entry into a handler is modelled as a fixed 12-cycle window. The vector is presented during this window. If a strictly more urgent request arrives before the last cycle of the window, it replaces the one being entered, and the window keeps counting without restarting. When the core reports a handler exit and a pending request is more urgent than whatever would remain active, the block goes straight into that request through a short 3-cycle chained window. It does not return to the base level and then start a full entry.

Software reaches the enable, priority, pending and active state through a one-cycle write port with a combinational read port. The bus address is split into a region field and a word field.

Top module: `irq_arbiter`

## Requirements
- R1: The pending bit of a line is set in every cycle in which its request input is high. A line whose enable bit is 0 is never entered, but its pending bit can still be read as 1.
- R2: The candidate is the pending, enabled line with the lowest priority value. When several lines share that value, the lowest line number wins.
- R3: An entry holds `vec_valid` high for exactly 12 cycles, with `vec_id` showing the line. `hdl_start` is high in the last of these cycles. On the next cycle that line reads as active (`act_valid`=1, `act_id`=line) and its pending bit is 0.
- R4: An entry begins only if the candidate's priority value is strictly less than the running level. The running level is the lowest priority value among active lines, or 16 when no line is active. An equal-priority request waits.
- R5: During an entry or chained window, a candidate with a strictly lower priority value than the line being entered replaces `vec_id` without restarting the count. An equal-priority request never replaces it, even on a lower line number. A replacement is not taken in the final cycle of the window.
- R6: When `core_exit` arrives and a candidate is strictly more urgent than the level left after the exit, the block enters a chained window. In that window `vec_valid` and `vec_chain` are both high for exactly 3 cycles, ending with `hdl_start`.
- R7: `core_exit` is taken only when no window is in progress and some line is active. It clears the active bit of the most urgent active line, and `act_id` falls back to the next active line (or `act_valid` goes low).
- R8: `vec_valid` stays low whenever no pending, enabled line beats the running level.
- R9: Register map, with region = `bus_addr[7:4]` and word = `bus_addr[3:0]`:
  - Region 0 holds the enables. Word w bit b is line 32w+b; read and write.
  - Region 1 holds the pending bits, in the same layout. Writing 1 clears a bit.
  - Region 2 holds the active bits, in the same layout. Writing 1 clears a bit.
  - Region 3 holds the priorities. Word w bits [4k+3:4k] are the priority of line 8w+k.
  - Bits with no line behind them read 0.
- R10: After reset, every enable, pending and active bit is 0, every priority is 0, and `vec_valid`, `vec_chain`, `hdl_start` and `act_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 41 | Interrupt request lines, sampled every cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address: region in [7:4], word in [3:0] |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from `bus_addr`) |
| core_exit | input | 1 | Core reports that the current handler has returned |
| vec_valid | output | 1 | An entry or chained window is in progress |
| vec_id | output | 6 | Line number being entered |
| vec_chain | output | 1 | The current window is a tail-chained one |
| hdl_start | output | 1 | Last cycle of the window; the line becomes active next cycle |
| act_valid | output | 1 | At least one handler is active |
| act_id | output | 6 | Most urgent active line |

## Verification
The assertions assume several things about the core and the software:
- Priority values do not change while a window is in progress, because the replacement check compares the priorities of the old and new vector.
- `core_exit` is raised only while a handler is running and no window is open.
- Software does not clear active bits behind the core's back.

The stimulus keeps within these limits. It programs all priorities and enables before the first request. It waits well past each 12-cycle window before it pulses `core_exit`. It touches the active region only to read it.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

    // Sequencer states: running (thread or handler), normal entry, chained entry
    typedef enum logic [1:0] {
        SEQ_RUN   = 2'd0,
        SEQ_ENTER = 2'd1,
        SEQ_CHAIN = 2'd2
    } seq_state_e;

    // Register regions selected by the upper address nibble
    localparam logic [3:0] RGN_EN   = 4'd0;
    localparam logic [3:0] RGN_PEND = 4'd1;
    localparam logic [3:0] RGN_ACT  = 4'd2;
    localparam logic [3:0] RGN_PRIO = 4'd3;

    typedef struct packed {
        logic [3:0] rgn;
        logic [3:0] word;
    } reg_addr_t;

    function automatic int unsigned words_for(int unsigned nbits);
        return (nbits + 31) / 32;
    endfunction

endpackage

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
// Scans a masked set of lines and returns the most urgent one.
// Ties go to the lowest line number because only a strictly lower value
// displaces an earlier hit.
module irq_pick #(
    parameter int unsigned N  = 41,
    parameter int unsigned PW = 4,
    parameter int unsigned IW = 6
) (
    input  logic [N-1:0]    mask,
    input  logic [N*PW-1:0] prio_flat,
    output logic            hit,
    output logic [IW-1:0]   idx,
    output logic [PW-1:0]   lvl
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        lvl = '0;
        for (int i = 0; i < N; i++) begin
            if (mask[i] && (!hit || (prio_flat[i*PW +: PW] < lvl))) begin
                hit = 1'b1;
                idx = IW'(i);
                lvl = prio_flat[i*PW +: PW];
            end
        end
    end

endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
// Per-line state: enable, priority, pending, active, plus the bus port.
module irq_regs
    import irq_arb_pkg::*;
#(
    parameter int unsigned N  = 41,
    parameter int unsigned PW = 4,
    parameter int unsigned IW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N-1:0]    irq_req,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic            act_set,
    input  logic [IW-1:0]   act_set_idx,
    input  logic            act_clr,
    input  logic [IW-1:0]   act_clr_idx,
    output logic [N-1:0]    en,
    output logic [N-1:0]    pend,
    output logic [N-1:0]    act,
    output logic [N*PW-1:0] prio_flat
);

    localparam int unsigned NWB = words_for(N);
    localparam int unsigned NWP = words_for(N * PW);

    reg_addr_t ra;
    assign ra = bus_addr;

    logic wr_en, wr_pend, wr_act, wr_prio;
    assign wr_en   = bus_wr && (ra.rgn == RGN_EN);
    assign wr_pend = bus_wr && (ra.rgn == RGN_PEND);
    assign wr_act  = bus_wr && (ra.rgn == RGN_ACT);
    assign wr_prio = bus_wr && (ra.rgn == RGN_PRIO);

    always_ff @(posedge clk) begin
        if (rst) begin
            en        <= '0;
            pend      <= '0;
            act       <= '0;
            prio_flat <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en && (ra.word == 4'(i / 32)))
                    en[i] <= bus_wdata[i % 32];
                if (wr_prio && (ra.word == 4'((i * PW) / 32)))
                    prio_flat[i*PW +: PW] <= bus_wdata[(i * PW) % 32 +: PW];
                // request wins over any clear in the same cycle
                pend[i] <= irq_req[i]
                         | (pend[i]
                            & ~(act_set && (act_set_idx == IW'(i)))
                            & ~(wr_pend && (ra.word == 4'(i / 32)) && bus_wdata[i % 32]));
                act[i]  <= (act_set && (act_set_idx == IW'(i)))
                         | (act[i]
                            & ~(act_clr && (act_clr_idx == IW'(i)))
                            & ~(wr_act && (ra.word == 4'(i / 32)) && bus_wdata[i % 32]));
            end
        end
    end

    logic [NWB*32-1:0] en_pad, pend_pad, act_pad;
    logic [NWP*32-1:0] prio_pad;
    assign en_pad   = (NWB*32)'(en);
    assign pend_pad = (NWB*32)'(pend);
    assign act_pad  = (NWB*32)'(act);
    assign prio_pad = (NWP*32)'(prio_flat);

    logic [31:0] widx;
    assign widx = 32'(ra.word);

    always_comb begin
        bus_rdata = '0;
        case (ra.rgn)
            RGN_EN:   if (widx < NWB) bus_rdata = en_pad[widx*32 +: 32];
            RGN_PEND: if (widx < NWB) bus_rdata = pend_pad[widx*32 +: 32];
            RGN_ACT:  if (widx < NWB) bus_rdata = act_pad[widx*32 +: 32];
            RGN_PRIO: if (widx < NWP) bus_rdata = prio_pad[widx*32 +: 32];
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_seq.sv
`timescale 1ns/1ps
// Entry / chain / exit sequencer with late-arrival replacement.
module irq_seq
    import irq_arb_pkg::*;
#(
    parameter int unsigned PW        = 4,
    parameter int unsigned IW        = 6,
    parameter int unsigned ENTRY_CYC = 12,
    parameter int unsigned TAIL_CYC  = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_exit,
    input  logic          cand_hit,
    input  logic [IW-1:0] cand_idx,
    input  logic [PW-1:0] cand_lvl,
    input  logic          top_hit,
    input  logic [IW-1:0] top_idx,
    input  logic [PW-1:0] top_lvl,
    input  logic          nxt_hit,
    input  logic [PW-1:0] nxt_lvl,
    output logic          vec_valid,
    output logic [IW-1:0] vec_id,
    output logic          vec_chain,
    output logic          hdl_start,
    output logic          act_set,
    output logic          act_clr,
    output logic [IW-1:0] act_clr_idx,
    output logic [PW:0]   run_lvl
);

    localparam int unsigned LW   = PW + 1;
    localparam int unsigned CMAX = (ENTRY_CYC > TAIL_CYC) ? ENTRY_CYC : TAIL_CYC;
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam logic [LW-1:0] BASE_LVL = LW'(1 << PW);

    seq_state_e     st;
    logic [CW-1:0]  cnt;
    logic [IW-1:0]  id_q;
    logic [PW-1:0]  lvl_q;
    logic           chain_q;

    logic [LW-1:0]  cand_l, after_lvl;
    logic           in_win, fin, do_exit;

    assign cand_l    = {1'b0, cand_lvl};
    assign run_lvl   = top_hit ? {1'b0, top_lvl} : BASE_LVL;
    assign after_lvl = nxt_hit ? {1'b0, nxt_lvl} : BASE_LVL;

    assign in_win  = (st != SEQ_RUN);
    assign fin     = in_win && (cnt == '0);
    assign do_exit = (st == SEQ_RUN) && core_exit && top_hit;

    assign vec_valid   = in_win;
    assign vec_id      = id_q;
    assign vec_chain   = in_win && chain_q;
    assign hdl_start   = fin;
    assign act_set     = fin;
    assign act_clr     = do_exit;
    assign act_clr_idx = top_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SEQ_RUN;
            cnt     <= '0;
            id_q    <= '0;
            lvl_q   <= '0;
            chain_q <= 1'b0;
        end else begin
            case (st)
                SEQ_RUN: begin
                    if (do_exit) begin
                        if (cand_hit && (cand_l < after_lvl)) begin
                            st      <= SEQ_CHAIN;
                            cnt     <= CW'(TAIL_CYC - 1);
                            id_q    <= cand_idx;
                            lvl_q   <= cand_lvl;
                            chain_q <= 1'b1;
                        end
                    end else if (cand_hit && (cand_l < run_lvl)) begin
                        st      <= SEQ_ENTER;
                        cnt     <= CW'(ENTRY_CYC - 1);
                        id_q    <= cand_idx;
                        lvl_q   <= cand_lvl;
                        chain_q <= 1'b0;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        st <= SEQ_RUN;
                    end else begin
                        cnt <= cnt - 1'b1;
                        if (cand_hit && (cand_lvl < lvl_q)) begin
                            id_q  <= cand_idx;
                            lvl_q <= cand_lvl;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
    parameter int unsigned N_IRQ     = 41,
    parameter int unsigned PRIO_W    = 4,
    parameter int unsigned ENTRY_CYC = 12,
    parameter int unsigned TAIL_CYC  = 3,
    localparam int unsigned ID_W     = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             core_exit,
    output logic             vec_valid,
    output logic [ID_W-1:0]  vec_id,
    output logic             vec_chain,
    output logic             hdl_start,
    output logic             act_valid,
    output logic [ID_W-1:0]  act_id
);

    logic [N_IRQ-1:0]        en, pend, act, nxt_mask;
    logic [N_IRQ*PRIO_W-1:0] prio_flat;

    logic                    cand_hit, top_hit, nxt_hit;
    logic [ID_W-1:0]         cand_idx, top_idx, nxt_idx_unused;
    logic [PRIO_W-1:0]       cand_lvl, top_lvl, nxt_lvl;
    logic [PRIO_W:0]         run_lvl;

    logic                    act_set, act_clr;
    logic [ID_W-1:0]         act_clr_idx;

    irq_regs #(.N(N_IRQ), .PW(PRIO_W), .IW(ID_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .irq_req     (irq_req),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .act_set     (act_set),
        .act_set_idx (vec_id),
        .act_clr     (act_clr),
        .act_clr_idx (act_clr_idx),
        .en          (en),
        .pend        (pend),
        .act         (act),
        .prio_flat   (prio_flat)
    );

    // most urgent pending and enabled request
    irq_pick #(.N(N_IRQ), .PW(PRIO_W), .IW(ID_W)) u_pick_cand (
        .mask      (pend & en),
        .prio_flat (prio_flat),
        .hit       (cand_hit),
        .idx       (cand_idx),
        .lvl       (cand_lvl)
    );

    // running handler: most urgent active line
    irq_pick #(.N(N_IRQ), .PW(PRIO_W), .IW(ID_W)) u_pick_top (
        .mask      (act),
        .prio_flat (prio_flat),
        .hit       (top_hit),
        .idx       (top_idx),
        .lvl       (top_lvl)
    );

    // level that remains once the running handler exits
    assign nxt_mask = act & ~(N_IRQ'(1) << top_idx);

    irq_pick #(.N(N_IRQ), .PW(PRIO_W), .IW(ID_W)) u_pick_nxt (
        .mask      (nxt_mask),
        .prio_flat (prio_flat),
        .hit       (nxt_hit),
        .idx       (nxt_idx_unused),
        .lvl       (nxt_lvl)
    );

    irq_seq #(.PW(PRIO_W), .IW(ID_W), .ENTRY_CYC(ENTRY_CYC), .TAIL_CYC(TAIL_CYC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .core_exit   (core_exit),
        .cand_hit    (cand_hit),
        .cand_idx    (cand_idx),
        .cand_lvl    (cand_lvl),
        .top_hit     (top_hit),
        .top_idx     (top_idx),
        .top_lvl     (top_lvl),
        .nxt_hit     (nxt_hit),
        .nxt_lvl     (nxt_lvl),
        .vec_valid   (vec_valid),
        .vec_id      (vec_id),
        .vec_chain   (vec_chain),
        .hdl_start   (hdl_start),
        .act_set     (act_set),
        .act_clr     (act_clr),
        .act_clr_idx (act_clr_idx),
        .run_lvl     (run_lvl)
    );

    assign act_valid = top_hit;
    assign act_id    = top_idx;

endmodule

// File: rtl/irq_arbiter_chk.sv
`timescale 1ns/1ps
module irq_arbiter_chk #(
    parameter int unsigned N_IRQ     = 41,
    parameter int unsigned PRIO_W    = 4,
    parameter int unsigned ID_W      = 6,
    parameter int unsigned ENTRY_CYC = 12,
    parameter int unsigned TAIL_CYC  = 3
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    vec_valid,
    input logic                    vec_chain,
    input logic [ID_W-1:0]         vec_id,
    input logic                    hdl_start,
    input logic                    act_valid,
    input logic [ID_W-1:0]         act_id,
    input logic                    cand_hit,
    input logic [PRIO_W-1:0]       cand_lvl,
    input logic [PRIO_W:0]         run_lvl,
    input logic [N_IRQ*PRIO_W-1:0] prio_flat
);

    // length of the current window, counted outside the sequencer
    logic [7:0]        win;
    logic [ID_W-1:0]   id_d;
    logic [PRIO_W-1:0] cur_p, old_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            win  <= '0;
            id_d <= '0;
        end else begin
            win  <= (vec_valid && !hdl_start) ? win + 8'd1 : 8'd0;
            id_d <= vec_id;
        end
    end

    assign cur_p = prio_flat[32'(vec_id) * PRIO_W +: PRIO_W];
    assign old_p = prio_flat[32'(id_d) * PRIO_W +: PRIO_W];

    assert_entry_len_R3: assert property (@(posedge clk) disable iff (rst)
        (hdl_start && !vec_chain) |-> (32'(win) == ENTRY_CYC - 1));

    assert_chain_len_R6: assert property (@(posedge clk) disable iff (rst)
        (hdl_start && vec_chain) |-> (32'(win) == TAIL_CYC - 1));

    assert_activate_R3: assert property (@(posedge clk) disable iff (rst)
        hdl_start |=> (act_valid && (act_id == $past(vec_id))));

    assert_replace_stricter_R5: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && $past(vec_valid) && (vec_id != id_d)) |-> (cur_p < old_p));

    assert_start_needs_cand_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_valid) |-> $past(cand_hit));

    assert_preempt_strict_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(vec_valid) && !vec_chain) |-> $past({1'b0, cand_lvl} < run_lvl));

endmodule

bind irq_arbiter irq_arbiter_chk #(
    .N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W),
    .ENTRY_CYC(ENTRY_CYC), .TAIL_CYC(TAIL_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vec_valid (vec_valid),
    .vec_chain (vec_chain),
    .vec_id    (vec_id),
    .hdl_start (hdl_start),
    .act_valid (act_valid),
    .act_id    (act_id),
    .cand_hit  (cand_hit),
    .cand_lvl  (cand_lvl),
    .run_lvl   (run_lvl),
    .prio_flat (prio_flat)
);

// File: tb/irq_arbiter_tb.sv
`timescale 1ns/1ps
module irq_arbiter_tb;

    localparam int N  = 41;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_req = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          core_exit = 1'b0;
    logic          vec_valid, vec_chain, hdl_start, act_valid;
    logic [IW-1:0] vec_id, act_id;

    always #10 clk = ~clk;   // 50 MHz

    irq_arbiter u_dut (
        .clk(clk), .rst(rst), .irq_req(irq_req),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_exit(core_exit), .vec_valid(vec_valid), .vec_id(vec_id), .vec_chain(vec_chain),
        .hdl_start(hdl_start), .act_valid(act_valid), .act_id(act_id)
    );

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int id;
        bit chain;
        int len;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(string tag, longint actual, longint expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, actual, expected);
        end
    endtask

    function automatic logic [N-1:0] bit_of(int k);
        return N'(1) << k;
    endfunction

    // driver side of the scoreboard
    task automatic expect_start(int id, bit chain);
        exp_t e;
        e.id = id;
        e.chain = chain;
        e.len = chain ? 3 : 12;
        sbq.push_back(e);
    endtask

    // monitor: pops one expected entry per handler start
    int vlen = 0;
    always @(negedge clk) begin
        if (rst) begin
            vlen = 0;
        end else begin
            if (vec_valid) vlen++;
            if (hdl_start) begin
                if (sbq.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R3 unexpected start: got id %0d expected none", vec_id);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk("R2/R5 vector id at start", vec_id, e.id);
                    chk("R6 chain flag at start", vec_chain, e.chain);
                    chk("R3/R6 window length", vlen, e.len);
                end
                vlen = 0;
            end
            if (!vec_valid) vlen = 0;
        end
    end

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic pulse(logic [N-1:0] m);
        @(posedge clk); #1;
        irq_req = m;
        @(posedge clk); #1;
        irq_req = '0;
    endtask

    task automatic exit_pulse();
        @(posedge clk); #1;
        core_exit = 1'b1;
        @(posedge clk); #1;
        core_exit = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic quiet_check(int n, string tag);
        bit seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (vec_valid) seen = 1'b1;
        end
        chk(tag, seen, 0);
    endtask

    task automatic sample_act(string tag, int v, int id);
        @(negedge clk);
        chk({tag, " act_valid"}, act_valid, v);
        if (v != 0) chk({tag, " act_id"}, act_id, id);
    endtask

    int pcfg[N];

    initial begin
        logic [31:0] rd;
        logic [31:0] w;

        for (int i = 0; i < N; i++) pcfg[i] = 15;
        pcfg[2] = 5;  pcfg[3] = 5;  pcfg[5] = 8;  pcfg[7] = 6;  pcfg[9] = 8;
        pcfg[12] = 6; pcfg[20] = 3; pcfg[30] = 10; pcfg[40] = 2;

        idle(3);
        #1 rst = 1'b0;

        // R10 reset state
        @(negedge clk);
        chk("R10 vec_valid after reset", vec_valid, 0);
        chk("R10 act_valid after reset", act_valid, 0);
        chk("R10 hdl_start after reset", hdl_start, 0);
        bus_read(8'h00, rd); chk("R10 enable word 0 reset", rd, 0);
        bus_read(8'h30, rd); chk("R10 priority word 0 reset", rd, 0);

        // R9 configuration and read-back (line 33 stays disabled)
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h01, 32'h0000_01FD);
        for (int wi = 0; wi < 6; wi++) begin
            w = '0;
            for (int k = 0; k < 8; k++)
                if (8*wi + k < N) w |= 32'(pcfg[8*wi + k]) << (4*k);
            bus_write(8'h30 + 8'(wi), w);
        end
        bus_read(8'h01, rd); chk("R9 enable word 1 read-back", rd, 32'h1FD);
        w = '0;
        for (int k = 0; k < 8; k++) w |= 32'(pcfg[16 + k]) << (4*k);
        bus_read(8'h32, rd); chk("R9 priority word 2 read-back", rd, w);
        bus_read(8'h35, rd); chk("R9 priority word 5 unused bits", rd, 32'h2);

        // R1 disabled line pends but is never entered
        pulse(bit_of(33));
        quiet_check(20, "R1 disabled line not entered");
        bus_read(8'h11, rd); chk("R1 pending bit of disabled line", rd, 32'h2);
        bus_write(8'h11, 32'h2);
        bus_read(8'h11, rd); chk("R9 pending write-1-clear", rd, 0);

        // R3 single entry
        expect_start(5, 0);
        pulse(bit_of(5));
        idle(20);
        sample_act("R3 after entry of line 5", 1, 5);
        bus_read(8'h10, rd); chk("R3 pending cleared on activation", rd, 0);
        bus_read(8'h20, rd); chk("R3 active bit set", rd, 32'h20);

        // R4 equal priority does not preempt
        pulse(bit_of(9));
        quiet_check(20, "R4 equal priority waits");

        // R4 strictly more urgent preempts
        expect_start(20, 0);
        pulse(bit_of(20));
        idle(20);
        sample_act("R4 nested preemption", 1, 20);
        bus_read(8'h20, rd); chk("R4 nested active bits", rd, (32'h1 << 5) | (32'h1 << 20));

        // R7 exit with only an equal candidate: fall back, no chain
        exit_pulse();
        idle(1);
        sample_act("R7 fall back to line 5", 1, 5);
        quiet_check(10, "R7 no chain for equal level");

        // R6 exit of line 5 tail-chains into line 9
        expect_start(9, 1);
        exit_pulse();
        idle(10);
        sample_act("R6 chained into line 9", 1, 9);
        bus_read(8'h20, rd); chk("R6 only line 9 active", rd, 32'h200);
        exit_pulse();
        idle(3);
        sample_act("R7 all handlers done", 0, 0);

        // R5 late arrival replaces the vector
        expect_start(40, 0);
        pulse(bit_of(30));
        idle(5);
        pulse(bit_of(40));
        idle(20);
        sample_act("R5 late arrival entered", 1, 40);
        expect_start(30, 1);
        exit_pulse();
        idle(10);
        sample_act("R6 chain to replaced line", 1, 30);
        exit_pulse();
        idle(3);

        // R2 tie goes to the lower line number
        expect_start(7, 0);
        expect_start(12, 1);
        pulse(bit_of(7) | bit_of(12));
        idle(20);
        sample_act("R2 tie winner", 1, 7);
        exit_pulse();
        idle(10);
        exit_pulse();
        idle(3);

        // R5 equal priority during entry does not replace
        expect_start(3, 0);
        expect_start(2, 1);
        pulse(bit_of(3));
        idle(5);
        pulse(bit_of(2));
        idle(20);
        sample_act("R5 equal late arrival ignored", 1, 3);
        exit_pulse();
        idle(10);
        exit_pulse();
        idle(3);

        // R8 nothing pending: no vector
        quiet_check(15, "R8 idle keeps vec_valid low");
        sample_act("R8 no handler active", 0, 0);
        chk("R3 scoreboard drained", sbq.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule